// File: doc/BRIEF.md
# Interrupt Request Flag and Enable Registers

This block keeps the interrupt state of a small 8-bit handheld-style system. Five peripherals each send a one-cycle request pulse: vertical blank, display status, timer overflow, serial transfer complete and keypad. Each pulse sets a sticky pending bit in a byte-wide flag register. The CPU can read that register and overwrite it over a simple byte bus. One write can acknowledge some requests and raise others in software.

A second byte-wide register holds the enable mask, which the CPU can read and write freely. The block ANDs the pending flags with the enable mask and drives the result as a per-source pending vector, together with a single any-pending line. The CPU core uses these to decide whether to take an interrupt. Choosing the winning source and dispatching it happen outside this block.

The bus uses a 16-bit address, a write strobe and write data. Read data is combinational, so it is valid in the same cycle as the address.

Top module: `irq_ctrl_regs`

## Requirements
- R1: After reset both registers are zero. A read at the flag address returns 8'hE0, a read at the enable address returns 8'h00, and pend_o and any_pend_o are 0.
- R2: A high pulse on req_i[k] sets flag bit k at the next clock edge, and the bit stays set until a CPU write clears it. Bit 0 is vertical blank, bit 1 display status, bit 2 timer overflow, bit 3 serial and bit 4 keypad.
- R3: A read at FLAG_ADDR (default 16'hFF0F) returns the five pending bits in bits 4..0, with bits 7..5 always 1.
- R4: A write at FLAG_ADDR loads flag bits 4..0 from bus_wdata[4:0] at the next edge. Bits 7..5 of the written byte have no effect.
- R5: When a request pulse and a flag write occur in the same cycle, the request wins and its bit ends up set.
- R6: A write at EN_ADDR (default 16'hFFFF) loads all 8 enable bits, and a read there returns them.
- R7: pend_o equals flags AND enable bits 4..0, so enable bits 7..5 never unmask anything. any_pend_o is the OR of pend_o.
- R8: A write to any other address changes neither register. A read at any other address returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 5 | One-cycle request pulses, one bit per source |
| bus_addr | input | 16 | CPU bus address |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pend_o | output | 5 | Enabled pending requests |
| any_pend_o | output | 1 | OR of pend_o |

## Verification
The bench targets a request pulse arriving in the same cycle as a clearing flag write. A design that lets the write win would silently lose that interrupt. It writes all ones to the flag register and checks that bits 7..5 still read as 1 and do not leak into pending state. It also sets enable bits 7..5 with live flags, which a design that masked with the full enable byte would report as pending. Flags are left idle across cycles to catch a design that drops a bit without an acknowledge. The bench also writes to a neighbouring address to catch decoding that matches too few address bits.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

  localparam int DATA_W = 8;
  localparam int SRC_N  = 5;

  // Source positions inside the flag register (order is visible to software)
  typedef enum int {
    SRC_VBLANK = 0,
    SRC_DISP   = 1,
    SRC_TIMER  = 2,
    SRC_SERIAL = 3,
    SRC_KEYPAD = 4
  } irq_src_e;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_FLAG = 2'd1,
    RD_EN   = 2'd2
  } rd_sel_e;

  // Next flag state: a written value replaces the flags, and requests OR on top
  function automatic logic [SRC_N-1:0] flag_next(
    input logic [SRC_N-1:0] cur,
    input logic [SRC_N-1:0] req,
    input logic             wr,
    input logic [SRC_N-1:0] wdata
  );
    logic [SRC_N-1:0] base;
    base = wr ? wdata : cur;
    return base | req;
  endfunction

  // Byte seen by the CPU: unused upper bits are tied high
  function automatic logic [DATA_W-1:0] flag_view(input logic [SRC_N-1:0] f);
    return {{(DATA_W-SRC_N){1'b1}}, f};
  endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_regs_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 16'hFFFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              flag_wr_hit,
  output logic              en_wr_hit,
  output rd_sel_e           rd_sel
);
  logic flag_match, en_match;

  always_comb begin
    flag_match  = (addr == FLAG_ADDR);
    en_match    = (addr == EN_ADDR);
    flag_wr_hit = wr & flag_match;
    en_wr_hit   = wr & en_match;
    if (flag_match)    rd_sel = RD_FLAG;
    else if (en_match) rd_sel = RD_EN;
    else               rd_sel = RD_NONE;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_regs_pkg::*;
#(
  parameter int NSRC = SRC_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic            wr_hit,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] flags
);
  genvar k;
  generate
    for (k = 0; k < NSRC; k++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n) flags[k] <= 1'b0;
        else        flags[k] <= (wr_hit ? wdata[k] : flags[k]) | req[k];
      end
    end
  endgenerate
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_regs_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en
);
  always_ff @(posedge clk) begin
    if (!rst_n)      en <= '0;
    else if (wr_hit) en <= wdata;
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_regs_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  req_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [SRC_N-1:0]  pend_o,
  output logic              any_pend_o
);
  logic              flag_wr_hit;
  logic              en_wr_hit;
  rd_sel_e           rd_sel;
  logic [SRC_N-1:0]  flag_q;
  logic [DATA_W-1:0] en_q;

  irq_bus_decode #(
    .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr),
    .flag_wr_hit(flag_wr_hit), .en_wr_hit(en_wr_hit), .rd_sel(rd_sel)
  );

  irq_flag_bank #(.NSRC(SRC_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .req(req_i),
    .wr_hit(flag_wr_hit), .wdata(bus_wdata[SRC_N-1:0]), .flags(flag_q)
  );

  irq_enable_reg #(.W(DATA_W)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_hit(en_wr_hit), .wdata(bus_wdata), .en(en_q)
  );

  always_comb begin
    unique case (rd_sel)
      RD_FLAG: bus_rdata = flag_view(flag_q);
      RD_EN:   bus_rdata = en_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pend_o     = flag_q & en_q[SRC_N-1:0];
  assign any_pend_o = |pend_o;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_regs_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'hFF0F,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 16'hFFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_N-1:0]  req_i,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [SRC_N-1:0]  pend_o,
  input logic              any_pend_o,
  input logic [SRC_N-1:0]  flag_q,
  input logic [DATA_W-1:0] en_q
);
  // R2 R5
  req_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |=> ((flag_q & $past(req_i)) == $past(req_i)));

  // R4
  flag_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == FLAG_ADDR && req_i == '0) |=> (flag_q == $past(bus_wdata[SRC_N-1:0])));

  // R6
  en_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == EN_ADDR) |=> (en_q == $past(bus_wdata)));

  // R3
  flag_upper_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == FLAG_ADDR) |-> (bus_rdata[DATA_W-1:SRC_N] == '1));

  // R7
  any_matches_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend_o == (pend_o != '0));

  // R7
  pend_within_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o & ~flag_q) == '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && req_i == '0) |=> ($stable(flag_q) && $stable(en_q)));
endmodule

bind irq_ctrl_regs irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pend_o(pend_o), .any_pend_o(any_pend_o), .flag_q(flag_q), .en_q(en_q)
);

// File: tb/irq_ctrl_regs_bench.sv
`timescale 1ns/1ps
module irq_ctrl_regs_bench;
  localparam logic [15:0] FA = 16'hFF0F;
  localparam logic [15:0] EA = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  req_i = '0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [4:0]  pend_o;
  logic        any_pend_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  irq_ctrl_regs u_irq_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_o(pend_o), .any_pend_o(any_pend_o)
  );

  // Vector: {enable[7:0], req[4:0], flag_wr, wdata[7:0], expected_flags[4:0]}
  localparam int NV = 8;
  localparam logic [26:0] VEC [NV] = '{
    {8'hFF, 5'b00001, 1'b0, 8'h00, 5'b00001},  // R2 vblank sets
    {8'hFF, 5'b00100, 1'b0, 8'h00, 5'b00101},  // R2 timer accumulates
    {8'h03, 5'b10000, 1'b0, 8'h00, 5'b10101},  // R7 partial mask
    {8'h1C, 5'b00000, 1'b1, 8'h0A, 5'b01010},  // R4 write loads
    {8'h00, 5'b00000, 1'b1, 8'hFF, 5'b11111},  // R4 upper bits dropped
    {8'h1F, 5'b00010, 1'b1, 8'h00, 5'b00010},  // R5 request beats clear
    {8'hE0, 5'b01000, 1'b0, 8'h00, 5'b01010},  // R7 upper enable bits
    {8'hFF, 5'b00000, 1'b1, 8'h00, 5'b00000}   // R4 acknowledge all
  };

  // Expected pending: walk the bits one at a time
  function automatic logic [4:0] model_pend(input logic [4:0] f, input logic [7:0] e);
    logic [4:0] r;
    for (int i = 0; i < 5; i++) r[i] = f[i] && e[i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic [4:0] rq);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d; req_i = rq;
    @(negedge clk);
    bus_wr = 1'b0; req_i = '0;
  endtask

  task automatic pulse(input logic [4:0] rq);
    @(negedge clk);
    req_i = rq;
    @(negedge clk);
    req_i = '0;
  endtask

  task automatic read_at(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic check_state(input string tag, input logic [4:0] ef, input logic [7:0] ee);
    logic [7:0] d;
    logic [4:0] ep;
    read_at(FA, d);
    check({tag, " flags"}, d, {3'b111, ef});
    read_at(EA, d);
    check({tag, " enable"}, d, ee);
    ep = model_pend(ef, ee);
    check({tag, " pend"}, {3'b000, pend_o}, {3'b000, ep});
    check({tag, " any"}, {7'd0, any_pend_o}, {7'd0, (ep != 5'd0)});
  endtask

  initial begin
    #100000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset", 5'b00000, 8'h00);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] en_v;
      logic [4:0] rq_v;
      en_v = VEC[v][26:19];
      rq_v = VEC[v][18:14];
      bus_write(EA, en_v, 5'b00000);
      if (VEC[v][13]) bus_write(FA, VEC[v][12:5], rq_v);
      else            pulse(rq_v);
      check_state($sformatf("R2 R4 R5 R6 R7 vec%0d", v), VEC[v][4:0], en_v);
    end

    // R2: each source bit by position, held across idle cycles
    bus_write(EA, 8'h1F, 5'b00000);
    for (int k = 0; k < 5; k++) begin
      bus_write(FA, 8'h00, 5'b00000);
      pulse(5'b00001 << k);
      repeat (4) @(negedge clk);
      check_state($sformatf("R2 src%0d held", k), 5'b00001 << k, 8'h1F);
    end

    // R8: neighbouring addresses ignore writes and read as zero
    bus_write(FA, 8'h05, 5'b00000);
    bus_write(16'hFF0E, 8'h1A, 5'b00000);
    bus_write(16'hFFFE, 8'h00, 5'b00000);
    bus_write(16'h7F0F, 8'h00, 5'b00000);
    check_state("R8 stray writes", 5'b00101, 8'h1F);
    read_at(16'hFF10, d);
    check("R8 unmapped read", d, 8'h00);

    // R6: full byte round trip
    bus_write(EA, 8'hA5, 5'b00000);
    read_at(EA, d);
    check("R6 enable readback", d, 8'hA5);

    // R1: reset after activity
    bus_write(FA, 8'h1F, 5'b00000);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 re-reset", 5'b00000, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule